// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block is a countdown timer that software reaches through a small register bus with four words: a reload value, the live count, a control word and an interrupt acknowledge. While enabled, the counter drops by one on every pulse of the chosen tick-enable input. The timer offers two tick inputs, a slow one and a fast one, and a control bit picks between them. When a tick arrives while the count is already zero, the counter underflows and raises a level interrupt.

On underflow the counter does one of two things. In periodic mode it restarts from the stored reload value. In free-run mode it wraps to all ones and keeps counting. To arm a single event, software stops the timer, writes a new reload value (which also lands in the counter at once), and sets the enable bit again. A write of any value to the acknowledge word drops the interrupt.

Top module: `ivtimer`

## Requirements
- R1: After reset, the reload register, the count, the control bits and the interrupt all read zero.
- R2: The bus decodes byte offsets as follows: 0x0 is the reload value, 0x4 is the live count, 0x8 is control and 0xC is the acknowledge word. A read of 0xC or of any other offset returns zero. A read never changes any state.
- R3: A write to offset 0x0 stores the low CNT_W data bits as the reload value and copies them into the counter on the same clock edge. That edge applies no tick.
- R4: Control bit 7 enables counting, bit 6 selects periodic (reload) mode and bit 3 selects the fast tick input (clear selects the slow one). Every other control bit reads back as zero.
- R5: While bit 7 is clear, the count holds its value whatever the ticks do.
- R6: While enabled, each pulse of the selected tick input lowers a nonzero count by one. Pulses on the unselected input have no effect.
- R7: A selected tick at count zero is an underflow. In periodic mode the counter then reloads from the reload register.
- R8: In free-run mode, an underflow wraps the counter to all ones.
- R9: The interrupt output rises on the clock edge of an underflow. It stays high until a write of any data to offset 0xC. If an underflow and that write fall on the same edge, the interrupt stays high.
- R10: CNT_W may be 16 or 32. Any reload value up to all ones is accepted, and write data above CNT_W bits is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Byte offset of the accessed word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| tick_slow | input | 1 | Slow tick-enable pulse |
| tick_fast | input | 1 | Fast tick-enable pulse |
| irq | output | 1 | Level interrupt, set on underflow |

## Verification
The two tick inputs pulse at different rates, every second cycle and every fifth cycle. A count that followed the wrong input would therefore drift away from the reference model within a few cycles. Periodic and free-run runs both go through underflow, and the value read back on the cycle the interrupt rises tells a reload apart from a wrap to all ones. A stopped timer with ticks still arriving shows that counting truly halts. Reload writes during a run, acknowledge writes with arbitrary data, and an all-ones reload value exercise the edge cases of the reload register and of the interrupt flag.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
   localparam int unsigned REG_AW = 4;

   localparam logic [REG_AW-1:0] OFS_RELOAD = 4'h0;
   localparam logic [REG_AW-1:0] OFS_COUNT  = 4'h4;
   localparam logic [REG_AW-1:0] OFS_CTRL   = 4'h8;
   localparam logic [REG_AW-1:0] OFS_ACK    = 4'hC;

   localparam int unsigned BIT_RUN    = 7;
   localparam int unsigned BIT_REPEAT = 6;
   localparam int unsigned BIT_FAST   = 3;

   typedef struct packed {
      logic run;
      logic repeat_mode;
      logic fast;
   } ivt_ctrl_t;

   function automatic logic [7:0] ctrl_to_byte(ivt_ctrl_t c);
      logic [7:0] b;
      b = '0;
      b[BIT_RUN]    = c.run;
      b[BIT_REPEAT] = c.repeat_mode;
      b[BIT_FAST]   = c.fast;
      return b;
   endfunction
endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
   import ivt_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              reload_wr,
   output logic              ack_wr,
   output logic [CNT_W-1:0]  reload_val,
   output ivt_ctrl_t         ctrl
);
   logic ctrl_wr;

   assign reload_wr = bus_we && (bus_addr == OFS_RELOAD);
   assign ctrl_wr   = bus_we && (bus_addr == OFS_CTRL);
   assign ack_wr    = bus_we && (bus_addr == OFS_ACK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_val <= '0;
      end else if (reload_wr) begin
         reload_val <= bus_wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (ctrl_wr) begin
         ctrl.run         <= bus_wdata[BIT_RUN];
         ctrl.repeat_mode <= bus_wdata[BIT_REPEAT];
         ctrl.fast        <= bus_wdata[BIT_FAST];
      end
   end
endmodule

// File: rtl/ivt_tick_sel.sv
module ivt_tick_sel (
   input  logic use_fast,
   input  logic tick_slow,
   input  logic tick_fast,
   output logic tick
);
   always_comb begin
      tick = use_fast ? tick_fast : tick_slow;
   end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_now,
   input  logic [CNT_W-1:0] load_data,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             run,
   input  logic             repeat_mode,
   input  logic             tick,
   output logic [CNT_W-1:0] count,
   output logic             underflow
);
   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

   logic step;
   logic at_zero;
   logic [CNT_W-1:0] after_zero;

   assign step      = run && tick && !load_now;
   assign at_zero   = (count == '0);
   assign underflow = step && at_zero;

   always_comb begin
      after_zero = repeat_mode ? reload_val : ALL_ONES;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load_now) begin
         count <= load_data;
      end else if (step) begin
         count <= at_zero ? after_zero : (count - ONE);
      end
   end
endmodule

// File: rtl/ivt_irq_flag.sv
module ivt_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic ack_evt,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (set_evt) begin
         flag <= 1'b1;
      end else if (ack_evt) begin
         flag <= 1'b0;
      end
   end
endmodule

// File: rtl/ivtimer.sv
module ivtimer
   import ivt_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tick_slow,
   input  logic              tick_fast,
   output logic              irq
);
   localparam int unsigned PAD_W = DATA_W - CNT_W;

   if (!(CNT_W == 16 || CNT_W == 32)) begin : g_bad_width
      $error("ivtimer: CNT_W must be 16 or 32");
   end
   if (DATA_W < CNT_W || DATA_W < 8) begin : g_bad_data
      $error("ivtimer: DATA_W must hold the count and the control byte");
   end

   logic             reload_wr;
   logic             ack_wr;
   logic [CNT_W-1:0] reload_q;
   ivt_ctrl_t        ctrl_q;
   logic             sel_tick;
   logic [CNT_W-1:0] cnt_q;
   logic             uf;
   logic [DATA_W-1:0] cnt_word;
   logic [DATA_W-1:0] reload_word;
   logic [DATA_W-1:0] ctrl_word;

   ivt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .reload_wr  (reload_wr),
      .ack_wr     (ack_wr),
      .reload_val (reload_q),
      .ctrl       (ctrl_q)
   );

   ivt_tick_sel u_tick (
      .use_fast  (ctrl_q.fast),
      .tick_slow (tick_slow),
      .tick_fast (tick_fast),
      .tick      (sel_tick)
   );

   ivt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_now    (reload_wr),
      .load_data   (bus_wdata[CNT_W-1:0]),
      .reload_val  (reload_q),
      .run         (ctrl_q.run),
      .repeat_mode (ctrl_q.repeat_mode),
      .tick        (sel_tick),
      .count       (cnt_q),
      .underflow   (uf)
   );

   ivt_irq_flag u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (uf),
      .ack_evt (ack_wr),
      .flag    (irq)
   );

   if (PAD_W == 0) begin : g_full
      assign cnt_word    = cnt_q;
      assign reload_word = reload_q;
   end else begin : g_pad
      assign cnt_word    = {{PAD_W{1'b0}}, cnt_q};
      assign reload_word = {{PAD_W{1'b0}}, reload_q};
   end
   assign ctrl_word = {{(DATA_W-8){1'b0}}, ctrl_to_byte(ctrl_q)};

   always_comb begin
      unique case (bus_addr)
         OFS_RELOAD: bus_rdata = reload_word;
         OFS_COUNT:  bus_rdata = cnt_word;
         OFS_CTRL:   bus_rdata = ctrl_word;
         default:    bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/ivt_chk.sv
module ivt_chk
   import ivt_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [REG_AW-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              run,
   input logic              repeat_mode,
   input logic              tick,
   input logic [CNT_W-1:0]  count,
   input logic [CNT_W-1:0]  reload_val,
   input logic              underflow,
   input logic              irq
);
   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

   logic ld;
   logic ack;
   assign ld  = bus_we && (bus_addr == OFS_RELOAD);
   assign ack = bus_we && (bus_addr == OFS_ACK);

   assert_load_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> count == $past(bus_wdata[CNT_W-1:0]));

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ld) |=> $stable(count));

   assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !ld && count != '0) |=> count == $past(count) - ONE);

   assert_uf_detect_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !ld && count == '0) |-> underflow);

   assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow && repeat_mode) |=> count == $past(reload_val));

   assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow && !repeat_mode) |=> count == ALL_ONES);

   assert_irq_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> irq);

   assert_irq_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !underflow) |=> !irq);

   assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack) |=> irq);
endmodule

bind ivtimer ivt_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_we      (bus_we),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .run         (ctrl_q.run),
   .repeat_mode (ctrl_q.repeat_mode),
   .tick        (sel_tick),
   .count       (cnt_q),
   .reload_val  (reload_q),
   .underflow   (uf),
   .irq         (irq)
);

// File: tb/ivtimer_tb.sv
module ivtimer_tb;
   localparam int unsigned CNT_W  = 32;
   localparam int unsigned DATA_W = 32;
   localparam logic [31:0] MASK   = 32'hFFFF_FFFF;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_we = 1'b0;
   logic [3:0]        bus_addr = 4'h0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              tick_slow = 1'b0;
   logic              tick_fast = 1'b0;
   logic              irq;

   int n_run = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ivtimer #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tick_slow(tick_slow), .tick_fast(tick_fast), .irq(irq)
   );

   // tick generators: fast every 2nd cycle, slow every 5th
   int phase = 0;
   always @(negedge clk) begin
      phase <= phase + 1;
      tick_fast <= (phase % 2) == 0;
      tick_slow <= (phase % 5) == 0;
   end

   // behavioural reference model
   logic [31:0] m_load, m_cnt;
   bit m_run, m_rep, m_fast, m_irq;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_load = 0; m_cnt = 0; m_run = 0; m_rep = 0; m_fast = 0; m_irq = 0;
      end else begin
         bit tk, ldw, uf_now;
         tk = m_fast ? tick_fast : tick_slow;
         ldw = bus_we && bus_addr == 4'h0;
         uf_now = !ldw && m_run && tk && m_cnt == 0;
         if (ldw) begin
            m_load = bus_wdata & MASK;
            m_cnt = m_load;
         end else if (m_run && tk) begin
            if (m_cnt == 0) m_cnt = m_rep ? m_load : MASK;
            else m_cnt = m_cnt - 1;
         end
         if (uf_now) m_irq = 1;
         else if (bus_we && bus_addr == 4'hC) m_irq = 0;
         if (bus_we && bus_addr == 4'h8) begin
            m_run = bus_wdata[7]; m_rep = bus_wdata[6]; m_fast = bus_wdata[3];
         end
      end
   end

   function automatic logic [31:0] model_read(logic [3:0] a);
      case (a)
         4'h0: return m_load;
         4'h4: return m_cnt;
         4'h8: return {24'h0, m_run, m_rep, 2'b00, m_fast, 3'b000};
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model (R2, R5, R6, R7, R8, R9)
   always @(negedge clk) begin
      #2;
      if (rst_n && !done) begin
         check(irq == m_irq, "R9 irq vs model", {31'b0, irq}, {31'b0, m_irq});
         check(bus_rdata == model_read(bus_addr), "R2/R6 read vs model", bus_rdata, model_read(bus_addr));
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
         finish_run();
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      bus_addr = a;
      #2;
      check(bus_rdata == exp, req, bus_rdata, exp);
   endtask

   task automatic wait_irq(input int limit);
      bus_addr = 4'h4;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk); #2;
         if (irq) return;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd_check(4'h0, 32'h0, "R1 reload after reset");
      rd_check(4'h4, 32'h0, "R1 count after reset");
      rd_check(4'h8, 32'h0, "R1 ctrl after reset");
      check(irq == 1'b0, "R1 irq after reset", {31'b0, irq}, 32'h0);

      // R3 load copies into counter; R5 hold while stopped
      wr(4'h0, 32'd5);
      rd_check(4'h4, 32'd5, "R3 count after reload write");
      repeat (20) @(negedge clk);
      rd_check(4'h4, 32'd5, "R5 count holds while stopped");

      // R4 control readback
      wr(4'h8, 32'hFF);
      rd_check(4'h8, 32'h0000_00C8, "R4 ctrl readback masks other bits");

      // R7 periodic reload on fast ticks
      wr(4'h0, 32'd5);
      wait_irq(200);
      check(irq == 1'b1, "R9 irq rises on underflow", {31'b0, irq}, 32'h1);
      check(bus_rdata == 32'd5, "R7 periodic reload value", bus_rdata, 32'd5);
      repeat (6) @(negedge clk);
      check(irq == 1'b1, "R9 irq held until ack", {31'b0, irq}, 32'h1);
      wr(4'hC, 32'hDEAD_BEEF);
      #2;
      check(irq == 1'b0, "R9 ack with arbitrary data", {31'b0, irq}, 32'h0);

      // R6 slow tick selected, periodic
      wr(4'h8, 32'h0000_00C0);
      wr(4'h0, 32'd3);
      repeat (40) @(negedge clk);
      wr(4'hC, 32'h0);

      // R8 free-run wrap
      wr(4'h8, 32'h0);
      wr(4'h0, 32'd2);
      wr(4'h8, 32'h0000_0088);
      wait_irq(200);
      check(irq == 1'b1, "R9 irq on free-run underflow", {31'b0, irq}, 32'h1);
      check(bus_rdata == MASK, "R8 wrap to all ones", bus_rdata, MASK);
      repeat (8) @(negedge clk);

      // R3 reload write during run re-arms
      wr(4'h0, 32'd1);
      repeat (12) @(negedge clk);

      // R10 all-ones reload accepted
      wr(4'h8, 32'h0);
      wr(4'h0, 32'hFFFF_FFFF);
      rd_check(4'h0, MASK, "R10 all-ones reload readback");
      rd_check(4'h4, MASK, "R10 all-ones count readback");

      // R2 unmapped and ack reads return zero, no side effects
      rd_check(4'hC, 32'h0, "R2 ack offset reads zero");
      rd_check(4'h2, 32'h0, "R2 unmapped offset reads zero");
      rd_check(4'h4, MASK, "R2 read has no side effect");

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule